// File: doc/BRIEF.md
# Parity-Protected Message Memory Controller

This block sits in front of a word-organized message store and guards every 32-bit word with one extra bit. When protection is switched on, the controller computes the bit on each write and checks it on each read. When protection is switched off, writes keep the stored protection bit as it was and reads are not checked. A read always returns its data, whether or not the check fails.

The memory holds message objects. Each object is a fixed group of consecutive words. A failed check has four effects. It sets a sticky error flag. It records the address of the first failing word. It emits a one-cycle strobe that names the object, so the object's valid flag can be cleared and the object is not transmitted. If error interrupts are enabled, it also pulses an interrupt. Software clears the flag and the captured address through a clear input.

Top module: `msgram_parity_ctrl`

## Requirements
- R1: A read request returns its data with one cycle of latency. `rd_valid` is high for exactly one cycle, in the cycle after a read request, and never after a write or an idle cycle.
- R2: While `par_en` is 1, a write stores the XOR of its 32 data bits as the protection bit. A later read with `par_en` = 1 of a word written this way reports no mismatch.
- R3: A write made while `par_en` is 0 updates the data but leaves the stored protection bit unchanged. A later checked read of a word whose new data has a different XOR therefore reports a mismatch.
- R4: A read made while `par_en` is 0 performs no check. It raises no `obj_inval`, no `err_irq` and no change to `par_err`.
- R5: A mismatch sets `par_err` in the cycle after `rd_valid`. `par_err` stays set until `err_clr` is pulsed.
- R6: `err_irq` pulses for one cycle, together with the `par_err` update, only if `err_irq_en` is 1 when the mismatch is detected.
- R7: On every mismatch, `obj_inval` pulses for one cycle, and `obj_idx` at the same time holds the failing word address divided by `WORDS_PER_OBJ` (4 by default, so address bits [5:2]).
- R8: `err_addr` captures the word address of the first mismatch while `par_err` is clear. It holds that value through later mismatches until `err_clr` is pulsed.
- R9: A read that fails its check still returns the stored data word on `rd_data`.
- R10: After reset, `rd_valid`, `par_err`, `err_irq`, `obj_inval`, `err_addr` and `obj_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| par_en | input | 1 | Enables protection bit generation and checking |
| err_irq_en | input | 1 | Enables the error interrupt |
| err_clr | input | 1 | Clears the error flag and the captured address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| par_err | output | 1 | Sticky mismatch flag |
| err_addr | output | ADDR_W | Address of the first failing word |
| err_irq | output | 1 | Error interrupt pulse |
| obj_inval | output | 1 | Strobe to clear the failing object's valid flag |
| obj_idx | output | ADDR_W-OBJ_SH | Index of the object to invalidate |

## Verification
The main function is tried with words of odd weight (one bit set), even weight (two bits set) and all ones. This shows that the stored bit follows the XOR and not a fixed value. Reads after writes made with protection off separate the case where the old bit is kept (a mismatch appears on the changed word) from the case where it is rewritten. Unchecked reads of the same corrupted word separate a skipped check from a passing one. Failures at two addresses in different objects show the first-address capture and the object index. A failure with interrupts off separates the interrupt path from the invalidation path.

// File: rtl/msgram_parity_pkg.sv
package msgram_parity_pkg;
  function automatic logic word_parity(input logic [31:0] w);
    return ^w;
  endfunction
endpackage

// File: rtl/mp_store.sv
module mp_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              par_en,
  output logic              rv_q,
  output logic [DATA_W-1:0] data_q,
  output logic              pbit_q,
  output logic              chk_q,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem  [DEPTH];
  logic              pmem [DEPTH];

  wire do_wr = req_valid & req_write;

  // data array: written on every write, read-first output register
  always_ff @(posedge clk) begin
    if (do_wr) mem[req_addr] <= req_wdata;
    if (rst) data_q <= '0;
    else     data_q <= mem[req_addr];
  end

  // protection bits: only touched while protection is on
  always_ff @(posedge clk) begin
    if (do_wr && par_en) pmem[req_addr] <= ^req_wdata;
    pbit_q <= pmem[req_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q   <= 1'b0;
      chk_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      rv_q   <= req_valid & ~req_write;
      chk_q  <= par_en;
      addr_q <= req_addr;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rv_q);  // R1
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rv_q);  // R1
endmodule

// File: rtl/mp_check.sv
module mp_check #(
  parameter int DATA_W = 32
) (
  input  logic              rv_q,
  input  logic              chk_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic              pbit_q,
  output logic              mismatch
);
  import msgram_parity_pkg::*;
  always_comb mismatch = rv_q & chk_q & (word_parity(data_q) != pbit_q);
endmodule

// File: rtl/mp_err_log.sv
module mp_err_log #(
  parameter int ADDR_W = 6,
  parameter int OBJ_SH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mismatch,
  input  logic [ADDR_W-1:0]        fail_addr,
  input  logic                     irq_en,
  input  logic                     clr,
  output logic                     flag,
  output logic [ADDR_W-1:0]        cap_addr,
  output logic                     irq,
  output logic                     inval,
  output logic [ADDR_W-OBJ_SH-1:0] obj
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      cap_addr <= '0;
      irq      <= 1'b0;
      inval    <= 1'b0;
      obj      <= '0;
    end else begin
      irq   <= mismatch & irq_en;
      inval <= mismatch;
      if (mismatch) obj <= fail_addr[ADDR_W-1:OBJ_SH];
      if (mismatch) begin
        flag <= 1'b1;
        if (!flag || clr) cap_addr <= fail_addr;
      end else if (clr) begin
        flag     <= 1'b0;
        cap_addr <= '0;
      end
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);  // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> $stable(cap_addr));  // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && inval));  // R6
endmodule

// File: rtl/msgram_parity_ctrl.sv
module msgram_parity_ctrl #(
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 6,
  parameter int WORDS_PER_OBJ  = 4,
  parameter int OBJ_SH         = $clog2(WORDS_PER_OBJ)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     par_en,
  input  logic                     err_irq_en,
  input  logic                     err_clr,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     par_err,
  output logic [ADDR_W-1:0]        err_addr,
  output logic                     err_irq,
  output logic                     obj_inval,
  output logic [ADDR_W-OBJ_SH-1:0] obj_idx
);
  logic              rv_q, pbit_q, chk_q, mismatch;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;

  mp_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .par_en(par_en),
    .rv_q(rv_q), .data_q(data_q), .pbit_q(pbit_q), .chk_q(chk_q),
    .addr_q(addr_q)
  );

  mp_check #(.DATA_W(DATA_W)) u_check (
    .rv_q(rv_q), .chk_q(chk_q), .data_q(data_q), .pbit_q(pbit_q),
    .mismatch(mismatch)
  );

  mp_err_log #(.ADDR_W(ADDR_W), .OBJ_SH(OBJ_SH)) u_log (
    .clk(clk), .rst(rst), .mismatch(mismatch), .fail_addr(addr_q),
    .irq_en(err_irq_en), .clr(err_clr), .flag(par_err),
    .cap_addr(err_addr), .irq(err_irq), .inval(obj_inval), .obj(obj_idx)
  );

  assign rd_valid = rv_q;
  assign rd_data  = data_q;

  AST_UNCHECKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !chk_q) |=> !obj_inval);  // R4
  AST_INVAL_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    obj_inval |-> $past(rd_valid));  // R7
  AST_INVAL_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    obj_inval |-> par_err);  // R5
endmodule

// File: tb/test_msgram_parity_ctrl.sv
module test_msgram_parity_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        par_en = 1'b1, err_irq_en = 1'b1, err_clr = 1'b0;
  logic        rd_valid, par_err, err_irq, obj_inval;
  logic [31:0] rd_data;
  logic [5:0]  err_addr;
  logic [3:0]  obj_idx;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msgram_parity_ctrl i_msgram_parity_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .par_en(par_en),
    .err_irq_en(err_irq_en), .err_clr(err_clr), .rd_valid(rd_valid),
    .rd_data(rd_data), .par_err(par_err), .err_addr(err_addr),
    .err_irq(err_irq), .obj_inval(obj_inval), .obj_idx(obj_idx)
  );

  typedef struct packed {
    logic        wr;
    logic        pen;
    logic [5:0]  addr;
    logic [31:0] data;
    logic        mis;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b1, 1'b1, 6'd5,  32'h0000_0001, 1'b0},  // R2 odd weight
    '{1'b0, 1'b1, 6'd5,  32'h0000_0001, 1'b0},  // R2
    '{1'b1, 1'b0, 6'd5,  32'h0000_0003, 1'b0},  // R3 keep old bit
    '{1'b0, 1'b0, 6'd5,  32'h0000_0003, 1'b0},  // R4 unchecked
    '{1'b0, 1'b1, 6'd5,  32'h0000_0003, 1'b1},  // R3 R9 mismatch
    '{1'b1, 1'b1, 6'd5,  32'h0000_0003, 1'b0},  // R2 repair
    '{1'b0, 1'b1, 6'd5,  32'h0000_0003, 1'b0},  // R2
    '{1'b1, 1'b1, 6'd9,  32'hFFFF_FFFF, 1'b0},  // R2 all ones
    '{1'b1, 1'b0, 6'd9,  32'h8000_0000, 1'b0},  // R3 odd, old bit 0
    '{1'b0, 1'b1, 6'd9,  32'h8000_0000, 1'b1}   // R3 R9
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge; one access takes two cycles plus one idle
  task automatic op(bit wr, bit pen, logic [5:0] a, logic [31:0] d,
                    bit exp_mis, bit exp_irq, bit do_chk, string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    par_en = pen;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (do_chk) begin
      chk({req, " rd_valid"}, 32'(rd_valid), 32'(!wr));
      if (!wr) chk({req, " rd_data"}, rd_data, d);
    end
    @(negedge clk);
    if (do_chk) begin
      chk({req, " rd_valid low"}, 32'(rd_valid), 32'd0);
      chk({req, " obj_inval"}, 32'(obj_inval), 32'(exp_mis));
      chk({req, " err_irq"}, 32'(err_irq), 32'(exp_irq));
    end
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rd_valid", 32'(rd_valid), 0);
    chk("R10 par_err", 32'(par_err), 0);
    chk("R10 err_irq", 32'(err_irq), 0);
    chk("R10 obj_inval", 32'(obj_inval), 0);
    chk("R10 err_addr", 32'(err_addr), 0);
    chk("R10 obj_idx", 32'(obj_idx), 0);
    rst = 1'b0;

    foreach (TBL[i]) begin
      op(TBL[i].wr, TBL[i].pen, TBL[i].addr, TBL[i].data,
         TBL[i].mis, TBL[i].mis, 1'b1, "R1/R2/R3/R4/R9 table");
      if (TBL[i].mis) begin
        chk("R5 flag set", 32'(par_err), 1);
        chk("R7 obj_idx", 32'(obj_idx), 32'(TBL[i].addr >> 2));
      end
    end
    // first failure was word 5; word 9 failure must not overwrite it
    chk("R8 first address kept", 32'(err_addr), 5);
    chk("R7 object of word 9", 32'(obj_idx), 2);

    // R4: unchecked read of corrupted word 9 leaves flag alone
    op(1'b0, 1'b0, 6'd9, 32'h8000_0000, 1'b0, 1'b0, 1'b1, "R4 unchecked");
    chk("R4 flag unchanged", 32'(par_err), 1);

    // R5 sticky until clear
    repeat (3) @(negedge clk);
    chk("R5 sticky", 32'(par_err), 1);
    clear_err();
    chk("R5 cleared", 32'(par_err), 0);
    chk("R8 address cleared", 32'(err_addr), 0);

    // R6: interrupt disabled, invalidation still happens
    err_irq_en = 1'b0;
    op(1'b1, 1'b1, 6'd13, 32'h0000_0010, 1'b0, 1'b0, 1'b0, "setup");
    op(1'b1, 1'b0, 6'd13, 32'h0000_0030, 1'b0, 1'b0, 1'b0, "setup");
    op(1'b0, 1'b1, 6'd13, 32'h0000_0030, 1'b1, 1'b0, 1'b1, "R6 irq off");
    chk("R6 flag without irq", 32'(par_err), 1);
    chk("R8 capture after clear", 32'(err_addr), 13);
    chk("R7 object of word 13", 32'(obj_idx), 3);
    err_irq_en = 1'b1;
    @(negedge clk);
    chk("R7 strobe one cycle", 32'(obj_inval), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule